// File: doc/BRIEF.md
# SDRAM Refresh and Power-Mode Sequencer

This block sits on the controller side of an SDR SDRAM interface. It keeps the array contents alive and moves the device into and out of its low-power states. A free-running interval timer raises one refresh request per period. Before each refresh the sequencer closes every bank with a precharge-all command, waits out the precharge-to-refresh gap, and then issues the refresh. Requests that arrive while the main controller holds the command bus are counted and postponed. When the postponement limit is reached, the sequencer tells the controller to give up the bus.

On request, the sequencer puts the device into self refresh. It precharges all banks and then issues the refresh encoding with the clock enable low. It keeps the clock enable low for at least the minimum active time. To leave self refresh it raises the clock enable and issues only NOP commands for the exit time. Refresh scheduling then restarts from a full interval.

A deep power down request follows the same precharge path and then issues the power-down encoding with the clock enable low. When the request is released, the block raises the clock enable and flags that the memory must be fully re-initialised. It does nothing more until the main controller reports that initialisation is done.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it, `cke` is 1, the command bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `addr` is 0, and `seq_busy`, `yield_req` and `need_init` are 0.
- R2: The interval is REF_CYC = floor(REF_PERIOD_NS / CLK_PERIOD_NS) clock cycles. After reset, the first precharge goes out in cycle REF_CYC+1. With the bus free, each later refresh sequence starts REF_CYC cycles after the previous one.
- R3: Each refresh starts with precharge-all, which is command 0010 with addr bit 10 at 1 and every other addr bit at 0. The refresh command 0001, with addr all 0, follows exactly T_RP cycles later.
- R4: The sequencer leaves idle only in a cycle after one in which `host_busy` was 0. While `host_busy` is 1, timer expiries are counted, up to MAX_PEND. Once the bus is free, the sequencer issues one precharge/refresh pair per pending count, back to back, with one idle cycle between pairs.
- R5: `yield_req` is 1 exactly while the pending count equals MAX_PEND. It drops in the cycle after the refresh that lowers the count.
- R6: When `sr_req` is 1 and the bus is free, the sequencer issues a precharge-all. T_RP cycles later it issues command 0001 with `cke` at 0. `cke` then stays 0, and the bus carries NOP, for as long as `sr_req` stays 1.
- R7: Once self refresh is entered, `cke` stays 0 for at least T_RAS cycles, including the entry cycle, even if `sr_req` drops at once.
- R8: On leaving self refresh, `cke` returns to 1 and the bus carries NOP for max(T_XSR, 2) cycles. Then `seq_busy` falls. Any pending count is discarded at entry, and the next precharge comes REF_CYC+1 cycles after `seq_busy` falls.
- R9: A `dpd_req` issues a precharge-all and, T_RP cycles later, command 0110 with `cke` at 0. `cke` stays 0 until `dpd_req` falls.
- R10: When `dpd_req` falls, `cke` returns to 1 and `need_init` and `seq_busy` read 1 and 0. No command is issued until `init_done` is seen. The cycle after that, `need_init` drops, and the first precharge follows REF_CYC+1 cycles after that drop.
- R11: When requests compete at the start of a sequence, deep power down wins over self refresh, and self refresh wins over a pending refresh.
- R12: `seq_busy` is 1 from the precharge cycle through the refresh cycle, and 0 in the idle cycles around a refresh sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_busy | input | 1 | Main controller is using the command bus |
| sr_req | input | 1 | Level request to stay in self refresh |
| dpd_req | input | 1 | Level request to stay in deep power down |
| init_done | input | 1 | One-cycle pulse: re-initialisation finished |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (bit 10 selects all banks on precharge) |
| seq_busy | output | 1 | Sequencer owns the command bus |
| yield_req | output | 1 | Postponement limit reached, controller must release the bus |
| need_init | output | 1 | Device left deep power down and needs full initialisation |

## Verification
The assertions check on every cycle that the three timing rules hold:
- any refresh or power-down command is at least T_RP cycles after the last precharge;
- the clock enable never rises out of self refresh before T_RAS low cycles;
- no command follows a clock-enable rise before the exit window ends.

They also check that a sequence starts only after a cycle with the bus free, that a refresh never consumes an empty pending count, and that the re-initialisation flag appears only out of a low clock enable. Only the bench scenarios can show the exact cycle in which each command appears: the rounded interval, the back-to-back draining of postponed refreshes, the request priorities, the discarding of pending refreshes across self refresh, and the timer restart after either low-power exit.

// File: rtl/srseq_pkg.sv
package srseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_TRP, S_REF, S_SREF, S_SR_HOLD,
    S_SR_EXIT, S_DPD, S_DPD_HOLD, S_NEED_INIT
  } seq_state_t;

  typedef enum logic [1:0] { G_REF, G_SR, G_DPD } seq_goal_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_DPD = 4'b0110;

  // refresh interval rounded down to whole clock cycles
  function automatic int ref_cycles(input int period_ns, input int clk_ns);
    return period_ns / clk_ns;
  endfunction

  // self-refresh exit window never shorter than two clocks
  function automatic int xsr_cycles(input int t_xsr);
    return (t_xsr < 2) ? 2 : t_xsr;
  endfunction

  // width for stage and age counters, with headroom for saturation
  function automatic int stage_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return $clog2(m + 1) + 1;
  endfunction

endpackage

// File: rtl/srseq_interval_timer.sv
module srseq_interval_timer #(
  parameter int REF_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int TW = $clog2(REF_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(REF_CYC - 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n || hold)   remain <= RELOAD;
    else if (remain == '0) remain <= RELOAD;
    else                  remain <= remain - 1'b1;
  end

  assign tick = (remain == '0) && !hold;

endmodule

// File: rtl/srseq_pending.sv
module srseq_pending #(
  parameter int MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic any,
  output logic full
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PEND);

  logic [PW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc && !dec && count != LIMIT) count <= count + 1'b1;
    else if (dec && !inc && count != '0)    count <= count - 1'b1;
  end

  assign any  = (count != '0);
  assign full = (count == LIMIT);

  // a refresh is only ever spent against a recorded request
  assert_dec_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (count != '0));

endmodule

// File: rtl/srseq_stage_counter.sv
module srseq_stage_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || restart) count <= '0;
    else if (count != '1)  count <= count + 1'b1;
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import srseq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int REF_PERIOD_NS = 15625,
  parameter int T_RP          = 3,
  parameter int T_RAS         = 6,
  parameter int T_XSR         = 8,
  parameter int MAX_PEND      = 4,
  parameter int ADDR_W        = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_busy,
  input  logic              sr_req,
  input  logic              dpd_req,
  input  logic              init_done,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              seq_busy,
  output logic              yield_req,
  output logic              need_init
);
  localparam int REF_CYC = ref_cycles(REF_PERIOD_NS, CLK_PERIOD_NS);
  localparam int XSR_CYC = xsr_cycles(T_XSR);
  localparam int CNT_W   = stage_width(T_RP, T_RAS, XSR_CYC);
  localparam int AP_BIT  = 10;
  localparam logic [CNT_W-1:0] TRP_LAST  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] RAS_LAST  = CNT_W'(T_RAS - 2);
  localparam logic [CNT_W-1:0] XSR_LAST  = CNT_W'(XSR_CYC - 1);
  localparam logic [CNT_W-1:0] TRP_MIN   = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] RAS_MIN   = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] XSR_MIN   = CNT_W'(XSR_CYC);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  seq_state_t state, state_nx;
  seq_goal_t  goal, goal_nx;
  logic [CNT_W-1:0] stage_cnt;
  logic [3:0] cmd_bus;
  logic tick, pend_any, pend_full;
  logic timer_hold, ref_issue, pend_clr, start_seq;

  // ---------------- sub-blocks ----------------
  srseq_interval_timer #(.REF_CYC(REF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(timer_hold), .tick(tick));

  srseq_pending #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(ref_issue), .clr(pend_clr),
    .any(pend_any), .full(pend_full));

  srseq_stage_counter #(.W(CNT_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .restart(state_nx != state), .count(stage_cnt));

  // ---------------- sequencing ----------------
  assign start_seq = !host_busy && (dpd_req || sr_req || pend_any);

  always_comb begin
    state_nx = state;
    goal_nx  = goal;
    case (state)
      S_IDLE: if (start_seq) begin
        state_nx = S_PRE;
        goal_nx  = dpd_req ? G_DPD : (sr_req ? G_SR : G_REF);
      end
      S_PRE:  state_nx = S_TRP;
      S_TRP:  if (stage_cnt >= TRP_LAST)
                state_nx = (goal == G_DPD) ? S_DPD : ((goal == G_SR) ? S_SREF : S_REF);
      S_REF:      state_nx = S_IDLE;
      S_SREF:     state_nx = S_SR_HOLD;
      S_SR_HOLD:  if (!sr_req && stage_cnt >= RAS_LAST) state_nx = S_SR_EXIT;
      S_SR_EXIT:  if (stage_cnt >= XSR_LAST) state_nx = S_IDLE;
      S_DPD:      state_nx = S_DPD_HOLD;
      S_DPD_HOLD: if (!dpd_req) state_nx = S_NEED_INIT;
      S_NEED_INIT: if (init_done) state_nx = S_IDLE;
      default:    state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      goal  <= G_REF;
    end else begin
      state <= state_nx;
      goal  <= goal_nx;
    end
  end

  // ---------------- internal events ----------------
  assign ref_issue  = (state == S_REF);
  assign pend_clr   = (state == S_SREF) || (state == S_DPD);
  assign timer_hold = (state inside {S_SREF, S_SR_HOLD, S_SR_EXIT,
                                     S_DPD, S_DPD_HOLD, S_NEED_INIT});

  // ---------------- pin decode ----------------
  always_comb begin
    cmd_bus = CMD_NOP;
    addr    = '0;
    cke     = 1'b1;
    case (state)
      S_PRE:      begin cmd_bus = CMD_PRE; addr = ALL_BANKS; end
      S_REF:      cmd_bus = CMD_REF;
      S_SREF:     begin cmd_bus = CMD_REF; cke = 1'b0; end
      S_SR_HOLD:  cke = 1'b0;
      S_DPD:      begin cmd_bus = CMD_DPD; cke = 1'b0; end
      S_DPD_HOLD: cke = 1'b0;
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_bus;
  assign seq_busy  = !(state inside {S_IDLE, S_NEED_INIT});
  assign yield_req = pend_full;
  assign need_init = (state == S_NEED_INIT);

  // ---------------- verification ages ----------------
  logic [CNT_W-1:0] pre_age, low_len, rise_age;
  logic cmd_live;
  assign cmd_live = (cmd_bus != CMD_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_age  <= '1;
      low_len  <= '0;
      rise_age <= '1;
    end else begin
      if (cmd_bus == CMD_PRE)  pre_age <= CNT_W'(1);
      else if (pre_age != '1)  pre_age <= pre_age + 1'b1;
      if (!cke)                low_len <= (low_len != '1) ? low_len + 1'b1 : low_len;
      else                     low_len <= '0;
      if (!cke)                rise_age <= '0;
      else if (rise_age != '1) rise_age <= rise_age + 1'b1;
    end
  end

  assert_pre_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bus == CMD_REF || cmd_bus == CMD_DPD) |-> (pre_age >= TRP_MIN));

  assert_sr_min_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && goal == G_SR) |-> (low_len >= RAS_MIN));

  assert_exit_nops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_live && cke) |-> (rise_age >= XSR_MIN));

  assert_bus_free_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> !$past(host_busy));

  assert_init_after_dpd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(need_init) |-> !$past(cke));

endmodule

// File: tb/sdram_refresh_seq_test.sv
module sdram_refresh_seq_test;
  localparam int CLK_NS = 20;
  localparam int R      = 15625 / CLK_NS;
  localparam int TRP    = 3;
  localparam int TRAS   = 6;
  localparam int XSR    = (8 < 2) ? 2 : 8;
  localparam int MAXP   = 4;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, DPD = 4'b0110;
  localparam logic [12:0] A10 = 13'h0400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_busy = 1'b0, sr_req = 1'b0, dpd_req = 1'b0, init_done = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, seq_busy, yield_req, need_init;
  logic [12:0] addr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic cke_prev = 1'b1;

  typedef struct { int cyc; logic [3:0] cmd; logic cke; logic [12:0] addr; string rq; } ev_t;
  ev_t expq[$];

  always #(CLK_NS/2) clk = ~clk;

  sdram_refresh_seq uut (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .sr_req(sr_req),
    .dpd_req(dpd_req), .init_done(init_done), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .seq_busy(seq_busy), .yield_req(yield_req), .need_init(need_init));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cyc %0d: actual %0d expected %0d", rq, what, cyc, act, exp);
    end
  endtask

  task automatic push_ev(int c, logic [3:0] cmd, logic k, logic [12:0] a, string rq);
    ev_t e;
    e.cyc = c; e.cmd = cmd; e.cke = k; e.addr = a; e.rq = rq;
    expq.push_back(e);
  endtask

  task automatic push_refresh(int p, string rq);
    push_ev(p, PRE, 1'b1, A10, rq);
    push_ev(p + TRP, REF, 1'b1, 13'h0, rq);
  endtask

  task automatic goto(int k);
    while (cyc < k) @(negedge clk);
  endtask

  // scoreboard monitor: every command or clock-enable change is compared
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] seen;
      seen = {cs_n, ras_n, cas_n, we_n};
      if (seen != NOP || cke != cke_prev) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected event at cyc %0d: actual cmd %b cke %b expected none",
                   cyc, seen, cke);
        end else begin
          ev_t e;
          e = expq.pop_front();
          if (e.cyc != cyc || e.cmd != seen || e.cke != cke || e.addr != addr) begin
            fails++;
            $display("FAIL %s event: actual cyc %0d cmd %b cke %b addr %h expected cyc %0d cmd %b cke %b addr %h",
                     e.rq, cyc, seen, cke, addr, e.cyc, e.cmd, e.cke, e.addr);
          end
        end
      end
      cke_prev <= cke;
    end
  end

  initial begin
    int s, d, ii;
    s  = 9*R + 100;
    d  = 10*R + 200;
    ii = d + 51 + 2*R;

    // expected command stream
    push_refresh(R + 1, "R3");
    push_refresh(2*R + 1, "R2");
    for (int i = 0; i < MAXP; i++) push_refresh(6*R + 3 + 5*i, "R4");
    push_refresh(7*R + 1, "R2");
    push_ev(8*R + 6, PRE, 1'b1, A10, "R11");
    push_ev(8*R + 9, REF, 1'b0, 13'h0, "R6");
    push_ev(8*R + 31, NOP, 1'b1, 13'h0, "R8");
    push_refresh(9*R + 40, "R8");
    push_ev(s + 1, PRE, 1'b1, A10, "R6");
    push_ev(s + 4, REF, 1'b0, 13'h0, "R6");
    push_ev(s + 4 + TRAS, NOP, 1'b1, 13'h0, "R7");
    push_refresh(s + 4 + TRAS + XSR + R + 1, "R8");
    push_ev(d + 1, PRE, 1'b1, A10, "R11");
    push_ev(d + 4, DPD, 1'b0, 13'h0, "R9");
    push_ev(d + 51, NOP, 1'b1, 13'h0, "R10");
    push_refresh(ii + R + 2, "R10");

    repeat (3) @(negedge clk);
    chk("R1", "cke", cke, 1);
    chk("R1", "cmd", {cs_n, ras_n, cas_n, we_n}, NOP);
    chk("R1", "addr", addr, 0);
    chk("R1", "seq_busy", seq_busy, 0);
    chk("R1", "yield_req", yield_req, 0);
    chk("R1", "need_init", need_init, 0);
    rst_n = 1'b1;

    goto(R);       chk("R12", "seq_busy idle", seq_busy, 0);
    goto(R + 1);   chk("R12", "seq_busy pre", seq_busy, 1);
    goto(R + 4);   chk("R12", "seq_busy ref", seq_busy, 1);
    goto(R + 5);   chk("R12", "seq_busy after", seq_busy, 0);

    goto(2*R + 10); host_busy = 1'b1;
    goto(6*R - 1); chk("R5", "yield below limit", yield_req, 0);
    goto(6*R);     chk("R5", "yield at limit", yield_req, 1);
    goto(6*R + 2); host_busy = 1'b0;
    goto(6*R + 6); chk("R5", "yield before first refresh", yield_req, 1);
    goto(6*R + 7); chk("R5", "yield after first refresh", yield_req, 0);

    goto(8*R - 10); host_busy = 1'b1; sr_req = 1'b1;
    goto(8*R + 5);  host_busy = 1'b0;
    goto(8*R + 20); chk("R6", "cke in self refresh", cke, 0);
                    chk("R6", "seq_busy in self refresh", seq_busy, 1);
    goto(8*R + 30); sr_req = 1'b0;
    goto(8*R + 38); chk("R8", "seq_busy in exit window", seq_busy, 1);
    goto(8*R + 39); chk("R8", "seq_busy after exit", seq_busy, 0);

    goto(s);       sr_req = 1'b1;
    goto(s + 4);   sr_req = 1'b0;
    goto(s + 9);   chk("R7", "cke held low", cke, 0);

    goto(d);       dpd_req = 1'b1; sr_req = 1'b1;
    goto(d + 50);  chk("R9", "cke in power down", cke, 0);
                   chk("R10", "need_init before exit", need_init, 0);
                   dpd_req = 1'b0; sr_req = 1'b0;
    goto(d + 51);  chk("R10", "need_init on exit", need_init, 1);
                   chk("R10", "seq_busy on exit", seq_busy, 0);
    goto(ii);      chk("R10", "need_init held", need_init, 1);
                   init_done = 1'b1;
    goto(ii + 1);  init_done = 1'b0;
                   chk("R10", "need_init cleared", need_init, 0);

    goto(ii + R + 40);
    chk("R2", "expected events left", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog at cyc %0d: actual running expected finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule